// File: doc/BRIEF.md
# Packed SIMD saturating adder

This unit treats two 32-bit words as packed lanes and performs the same add or subtract on every lane in one clock. It offers two lane formats: four 8-bit lanes or two 16-bit lanes. Each lane is interpreted as signed or unsigned. Plain add and subtract either clamp to the lane range or wrap, and report overflow in both cases. The halving variants return (a±b)>>1 on the extended lane value, with optional rounding.

The result is registered. An overflow is reported as a write-enable plus a new value for a 32-bit control register. That new value is the caller's current register value with one fixed sticky flag bit set, so the surrounding datapath can apply it as a read-modify-write.

Top module: `simd_addsub`

## Requirements
- R1: With `lane_fmt`=0 the word holds four 8-bit lanes; with `lane_fmt`=1 it holds two 16-bit lanes. Lane i occupies bits [width*(i+1)-1 : width*i], and no carry crosses a lane boundary.
- R2: With `is_signed`=1 each lane is sign-extended before the arithmetic. With `is_signed`=0 each lane is zero-extended.
- R3: For `op`=00 (add) and `op`=01 (subtract) with `sat_en`=1, a lane result above the lane maximum becomes the maximum. A result below the lane minimum becomes the minimum. The limits are 2^(w-1)-1 and -2^(w-1) for signed lanes, and 2^w-1 and 0 for unsigned lanes.
- R4: For add and subtract with `sat_en`=0, each lane keeps the low w bits of the exact result.
- R5: When any lane of an add or subtract falls outside its range, `ctl_we` is 1 in the cycle after the operation. `ctl_out` then equals the sampled `ctl_in` with bit 20 set and every other bit unchanged.
- R6: When no lane overflows, or when `op_valid` is low, `ctl_we` stays 0.
- R7: For `op`=10 (halving add) and `op`=11 (halving subtract), each lane is (ext_a ± ext_b + r) shifted right arithmetically by one, keeping the low w bits, where r = `rnd_en`. `sat_en` has no effect on these ops.
- R8: Halving operations never assert `ctl_we`.
- R9: `result` updates one clock after a cycle with `op_valid`=1, and `res_valid` marks that cycle. `result` holds while `op_valid` is 0. Reset clears `result`, `ctl_we` and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| lane_fmt | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| is_signed | input | 1 | Lanes are two's complement |
| op | input | 2 | 00 add, 01 sub, 10 halving add, 11 halving sub |
| sat_en | input | 1 | Clamp instead of wrap for add/sub |
| rnd_en | input | 1 | Add one before the halving shift |
| a | input | 32 | First packed operand |
| b | input | 32 | Second packed operand |
| ctl_in | input | 32 | Current control register value |
| result | output | 32 | Registered packed result |
| res_valid | output | 1 | `result` was loaded on the last edge |
| ctl_we | output | 1 | Write the control register this cycle |
| ctl_out | output | 32 | New control register value |

## Verification
A lane that extends with the wrong sign, or a range test off by one, shows up in the very next `result` or in a `ctl_we` pulse where none is expected. Corruption of control bits other than the flag shows up in the same cycle as the write. Halving paths that leak into the overflow logic raise `ctl_we` one clock after the operation. Operands at 0x80, 0x7F, 0xFF, 0x8000 and 0x7FFF, under every format, sign and op mix, hit the clamp boundaries exactly. A per-cycle scoreboard therefore pins each fault to the cycle in which it occurs.

// File: rtl/simd_pkg.sv
package simd_pkg;
   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_SUB  = 2'b01,
      OP_HADD = 2'b10,
      OP_HSUB = 2'b11
   } simd_op_e;

   typedef enum logic {
      FMT_NARROW = 1'b0,
      FMT_WIDE   = 1'b1
   } lane_fmt_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sgn_i,
   input  logic [1:0]   op_i,
   input  logic         sat_i,
   input  logic         rnd_i,
   output logic [W-1:0] res_o,
   output logic         ovf_o
);
   localparam int XW = W + 2;

   logic signed [XW-1:0] ea, eb, raw, rsum, val, vmax, vmin;
   logic                 hi, lo, half_op, clamp;

   always_comb begin
      half_op = op_i[1];
      ea   = sgn_i ? {{2{a_i[W-1]}}, a_i} : {2'b00, a_i};
      eb   = sgn_i ? {{2{b_i[W-1]}}, b_i} : {2'b00, b_i};
      raw  = op_i[0] ? (ea - eb) : (ea + eb);
      rsum = raw + {{(XW-1){1'b0}}, rnd_i};
      val  = half_op ? (rsum >>> 1) : raw;
      vmax = sgn_i ? {3'b000, {(W-1){1'b1}}} : {2'b00, {W{1'b1}}};
      vmin = sgn_i ? {3'b111, {(W-1){1'b0}}} : '0;
      hi   = val > vmax;
      lo   = val < vmin;
      clamp = sat_i & ~half_op;
      ovf_o = ~half_op & (hi | lo);
      if (clamp && hi)      res_o = vmax[W-1:0];
      else if (clamp && lo) res_o = vmin[W-1:0];
      else                  res_o = val[W-1:0];
   end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank #(
   parameter int W = 8,
   parameter int N = 4
) (
   input  logic [N*W-1:0] a_i,
   input  logic [N*W-1:0] b_i,
   input  logic           sgn_i,
   input  logic [1:0]     op_i,
   input  logic           sat_i,
   input  logic           rnd_i,
   output logic [N*W-1:0] res_o,
   output logic           ovf_o
);
   logic [N-1:0] lane_ovf;

   for (genvar i = 0; i < N; i++) begin : g_lane
      simd_lane #(.W(W)) u_lane (
         .a_i   (a_i[i*W +: W]),
         .b_i   (b_i[i*W +: W]),
         .sgn_i (sgn_i),
         .op_i  (op_i),
         .sat_i (sat_i),
         .rnd_i (rnd_i),
         .res_o (res_o[i*W +: W]),
         .ovf_o (lane_ovf[i])
      );
   end

   assign ovf_o = |lane_ovf;
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub #(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16,
   parameter int FLAG_BIT = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              lane_fmt,
   input  logic              is_signed,
   input  logic [1:0]        op,
   input  logic              sat_en,
   input  logic              rnd_en,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] ctl_in,
   output logic [DATA_W-1:0] result,
   output logic              res_valid,
   output logic              ctl_we,
   output logic [DATA_W-1:0] ctl_out
);
   import simd_pkg::*;

   localparam int N_NARROW = DATA_W / NARROW_W;
   localparam int N_WIDE   = DATA_W / WIDE_W;
   localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

   if (DATA_W % NARROW_W != 0) begin : g_chk_narrow
      $error("DATA_W must be a multiple of NARROW_W");
   end
   if (DATA_W % WIDE_W != 0) begin : g_chk_wide
      $error("DATA_W must be a multiple of WIDE_W");
   end
   if (FLAG_BIT >= DATA_W) begin : g_chk_flag
      $error("FLAG_BIT outside control word");
   end

   logic [DATA_W-1:0] res_n, res_w, res_sel;
   logic              ovf_n, ovf_w, ovf_sel;

   simd_lane_bank #(.W(NARROW_W), .N(N_NARROW)) u_bank_n (
      .a_i(a), .b_i(b), .sgn_i(is_signed), .op_i(op),
      .sat_i(sat_en), .rnd_i(rnd_en), .res_o(res_n), .ovf_o(ovf_n)
   );

   simd_lane_bank #(.W(WIDE_W), .N(N_WIDE)) u_bank_w (
      .a_i(a), .b_i(b), .sgn_i(is_signed), .op_i(op),
      .sat_i(sat_en), .rnd_i(rnd_en), .res_o(res_w), .ovf_o(ovf_w)
   );

   always_comb begin
      if (lane_fmt_e'(lane_fmt) == FMT_WIDE) begin
         res_sel = res_w;
         ovf_sel = ovf_w;
      end else begin
         res_sel = res_n;
         ovf_sel = ovf_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         res_valid <= 1'b0;
         ctl_we    <= 1'b0;
         ctl_out   <= '0;
      end else begin
         res_valid <= op_valid;
         ctl_we    <= op_valid & ovf_sel;
         if (op_valid) begin
            result  <= res_sel;
            ctl_out <= ctl_in | FLAG_MASK;
         end
      end
   end

   // R5: a write carries the flag and preserves every other sampled bit
   p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |-> ctl_out[FLAG_BIT]);
   p_other_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |-> ((ctl_out & ~FLAG_MASK) == ($past(ctl_in) & ~FLAG_MASK)));
   // R6: no control write without an operation
   p_we_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |-> $past(op_valid));
   // R8: halving ops leave the control register alone
   p_half_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op[1]) |=> !ctl_we);
   // R9: result holds while idle
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(result));
endmodule

// File: tb/simd_addsub_tb.sv
`timescale 1ns/1ps
module simd_addsub_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        lane_fmt = 1'b0;
   logic        is_signed = 1'b0;
   logic [1:0]  op = 2'b00;
   logic        sat_en = 1'b0;
   logic        rnd_en = 1'b0;
   logic [31:0] a = '0, b = '0, ctl_in = '0;
   logic [31:0] result, ctl_out;
   logic        res_valid, ctl_we;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] q_res[$];
   logic        q_we[$];
   logic [31:0] q_ctl[$];
   string       q_tag[$];
   string       q_ftag[$];
   logic [31:0] last_res = '0;

   always #4 clk = ~clk;

   simd_addsub u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .lane_fmt(lane_fmt),
      .is_signed(is_signed), .op(op), .sat_en(sat_en), .rnd_en(rnd_en),
      .a(a), .b(b), .ctl_in(ctl_in), .result(result), .res_valid(res_valid),
      .ctl_we(ctl_we), .ctl_out(ctl_out)
   );

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Behavioural model from the requirements
   task automatic model(input bit fmt, input bit sgn, input bit [1:0] o, input bit sat,
                        input bit rnd, input logic [31:0] x, input logic [31:0] y,
                        output logic [31:0] r, output bit ovf);
      int w = fmt ? 16 : 8;
      int n = 32 / w;
      longint lim = longint'(1) << w;
      r = '0;
      ovf = 1'b0;
      for (int i = 0; i < n; i++) begin
         longint ea = (longint'(x) >> (w*i)) & (lim - 1);
         longint eb = (longint'(y) >> (w*i)) & (lim - 1);
         longint mx, mn, v;
         if (sgn && ea >= lim/2) ea -= lim;
         if (sgn && eb >= lim/2) eb -= lim;
         mx = sgn ? lim/2 - 1 : lim - 1;
         mn = sgn ? -lim/2 : 0;
         v = o[0] ? ea - eb : ea + eb;
         if (o[1]) begin
            v = (v + longint'(rnd)) >>> 1;
         end else if (v > mx || v < mn) begin
            ovf = 1'b1;
            if (sat) v = (v > mx) ? mx : mn;
         end
         r = r | (32'(v & (lim - 1)) << (w*i));
      end
   endtask

   task automatic issue(input bit fmt, input bit sgn, input bit [1:0] o, input bit sat,
                        input bit rnd, input logic [31:0] x, input logic [31:0] y,
                        input logic [31:0] c, input string tag);
      logic [31:0] r;
      bit ovf;
      @(negedge clk);
      op_valid = 1'b1; lane_fmt = fmt; is_signed = sgn; op = o;
      sat_en = sat; rnd_en = rnd; a = x; b = y; ctl_in = c;
      model(fmt, sgn, o, sat, rnd, x, y, r, ovf);
      q_res.push_back(r);
      q_we.push_back(ovf);
      q_ctl.push_back(c | 32'h0010_0000);
      q_tag.push_back(tag);
      q_ftag.push_back(ovf ? "R5" : (o[1] ? "R8" : "R6"));
      last_res = r;
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (res_valid) begin
            if (q_res.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R9: actual res_valid 1 expected 0 (no pending op)");
            end else begin
               logic [31:0] er, ec;
               logic ew;
               string t, ft;
               er = q_res.pop_front(); ew = q_we.pop_front();
               ec = q_ctl.pop_front(); t = q_tag.pop_front(); ft = q_ftag.pop_front();
               check32(t, result, er);
               check32(ft, {31'd0, ctl_we}, {31'd0, ew});
               if (ew) check32("R5", ctl_out, ec);
            end
         end else begin
            check32("R6", {31'd0, ctl_we}, 32'd0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check32("R9", result, 32'd0);
      check32("R9", {31'd0, ctl_we}, 32'd0);
      check32("R9", {31'd0, res_valid}, 32'd0);
      rst_n = 1'b1;

      // R1: lane layout, carries stay inside lanes
      issue(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 32'h00FF_0001, 32'h0001_0001, 32'h0, "R1");
      issue(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 32'h00FF_0001, 32'h0001_0001, 32'h0, "R1");
      issue(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 32'h0403_0201, 32'h1020_3040, 32'h0, "R1");
      // R2: signed versus unsigned interpretation
      issue(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 32'h0000_0080, 32'h0000_0080, 32'h0, "R2");
      issue(1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 32'h0000_0080, 32'h0000_0080, 32'h0, "R2");
      issue(1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 32'h0000_00FE, 32'h0000_0000, 32'h0, "R2");
      // R3: clamps at both ends
      issue(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 32'h7F7F_7F7F, 32'h0101_0101, 32'hFFEF_FFFF, "R3");
      issue(1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 32'h8080_8080, 32'h0101_0101, 32'h0000_1234, "R3");
      issue(1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 32'h0000_0000, 32'h0101_0101, 32'h0, "R3");
      issue(1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0101_0101, 32'h0, "R3");
      issue(1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 32'h7FFF_8000, 32'h0001_FFFF, 32'h0, "R3");
      issue(1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 32'h0001_8000, 32'h0002_7FFF, 32'h0, "R3");
      // R4: wrap keeps low bits, still flags
      issue(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 32'h7F7F_7F7F, 32'h0101_0101, 32'h0, "R4");
      issue(1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 32'h8000_8000, 32'h0001_0001, 32'hFFFF_FFFF, "R4");
      // R6: in-range ops do not write
      issue(1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 32'h1234_F000, 32'h0111_0FFF, 32'h0, "R6");
      // R7 / R8: halving with and without rounding, sat_en ignored
      issue(1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 32'h7F7F_0100, 32'h7F7F_0000, 32'h0, "R7");
      issue(1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 32'h7F7F_0100, 32'h7F7F_0000, 32'h0, "R7");
      issue(1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 32'h0000_0000, 32'hFF01_0203, 32'h0, "R7");
      issue(1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 32'h8000_7FFF, 32'h7FFF_8000, 32'h0, "R8");
      issue(1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R8");

      // Random sweep over every format, sign and op
      for (int k = 0; k < 600; k++) begin
         logic [31:0] x, y;
         bit [1:0] o;
         bit s;
         x = $urandom(); y = $urandom();
         if (k % 3 == 0) x = {4{8'h80 ^ 8'($urandom_range(0, 1))}};
         if (k % 5 == 0) y = {2{16'h7FFF + 16'($urandom_range(0, 1))}};
         o = 2'($urandom_range(0, 3));
         s = 1'($urandom_range(0, 1));
         issue(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), o, s,
               1'($urandom_range(0, 1)), x, y, $urandom(),
               o[1] ? "R7" : (s ? "R3" : "R4"));
      end

      // R9: result holds while idle
      @(negedge clk);
      op_valid = 1'b0; a = 32'hDEAD_BEEF; b = 32'h1234_5678;
      repeat (4) @(negedge clk);
      check32("R9", result, last_res);
      check32("R9", {31'd0, res_valid}, 32'd0);
      check32("R9", q_res.size(), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule